// File: doc/BRIEF.md
# Two-Bank Host Register Bus Interface with Write-Wait Timing

This block sits between an 8-bit host processor bus and the register files of a multi-voice sound device. The host drives chip select, read and write strobes, a bank select line and a register/data select line. An address cycle stores a register number. A following data cycle writes a byte to that stored register in the bank chosen by the bank select line. The block routes each data write to exactly one sub-unit: the square-tone generator, the drum-sample unit, the FM global registers, the FM per-channel registers or the sample-playback unit. With the strobe it hands over the stored register number, the data byte and the bank.

Each sub-unit needs a settling time after an access. The time differs for address cycles and data cycles and depends on the register range touched, from none up to 576 clocks. The block times this with one counter and shows a busy flag in bit 7 of both status bytes, so the host can poll before its next access. It also drives the data bus on reads. A read returns a status byte, a tone register value, a fixed identification byte or a sample-unit data byte. The bus is released whenever chip select is high. Each write is taken on the first clock that sees the write strobe active, so holding the strobe low does not repeat the write.

Top module: `sndbus_host_if`

## Requirements
- R1: After reset no strobe is pulsed, the busy flag is clear, `d_oe` is low and the stored register number `reg_addr` is 0x00.
- R2: A write cycle (`cs_n`=0, `wr_n`=0, `rd_n`=1) with `a0`=0 stores `d_in` as the register number. The number is kept until the next such cycle, so repeated data writes reuse it as `wr_addr`.
- R3: A write cycle with `a0`=1 pulses one strobe for exactly one clock, in the clock after the first clock that sees the cycle. With it, `wr_data` carries `d_in` and `wr_hi` carries `a1`. A write strobe held low for several clocks gives a single write.
- R4: Strobe bit positions in `unit_we`. Bit 0 is the tone unit (bank 0, 0x00–0x0F). Bit 1 is the drum unit (bank 0, 0x10–0x1F). Bit 2 is FM global (bank 0, 0x20–0x2F). Bit 3 is FM channel (0x30–0xB6 in either bank). Bit 4 is the sample unit (bank 1, 0x00–0x10). Any other register number pulses no strobe.
- R5: An address cycle that names a drum, FM global or FM channel register sets a wait of 17 clocks. Any other address cycle sets a wait of 0.
- R6: Data writes set these waits: FM global and FM channel 0x30–0x9E, 83 clocks; FM channel 0xA0–0xB6, 47 clocks; drum register 0x10, 576 clocks; drum 0x11–0x1F, 83 clocks; tone, sample and unmapped registers, 0.
- R7: With a wait of W loaded at a clock edge, the busy flag reads 1 for exactly the W clock periods that follow that edge, then 0.
- R8: A write that arrives while busy is accepted (its strobe pulses), and it restarts the wait with its own length.
- R9: A read cycle (`cs_n`=0, `rd_n`=0, `wr_n`=1) with `a0`=0 returns {busy, `stat0_flags`} when `a1`=0 and {busy, `stat1_flags`} when `a1`=1.
- R10: A read with `a0`=1 and `a1`=0 returns `tone_rdata` for stored numbers 0x00–0x0F, the ID parameter (default 0x01) for 0xFF, and 0x00 otherwise. With `a1`=1 it returns `adp_rdata` for 0x08 and 0x0F, and 0x00 otherwise.
- R11: `d_oe` is high only during a read cycle. When `d_oe` is low, `d_out` is 0x00, including whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a1 | input | 1 | Bank select |
| a0 | input | 1 | 0: address/status, 1: data |
| d_in | input | 8 | Host data bus, inbound |
| d_out | output | 8 | Host data bus, outbound |
| d_oe | output | 1 | Output enable for the bus driver |
| reg_addr | output | 8 | Stored register number, for sub-unit readback |
| unit_we | output | 5 | One-hot sub-unit write strobes |
| wr_addr | output | 8 | Register number of the current write |
| wr_data | output | 8 | Data byte of the current write |
| wr_hi | output | 1 | Bank of the current write |
| tone_rdata | input | 8 | Tone unit register value at `reg_addr` |
| adp_rdata | input | 8 | Sample unit read data |
| stat0_flags | input | 7 | Low flags of status byte 0 |
| stat1_flags | input | 7 | Low flags of status byte 1 |

## Verification
A write can land in the same clock in which an earlier wait would expire, or while an earlier wait still has many clocks left. The restart rule must then win over the countdown. The bench provokes this by polling the status byte during a long FM wait and issuing a second write part way through. It then counts the busy clocks that follow and expects the full length of the new wait. A reference model in the bench tracks the wait on every clock and compares the polled busy bit each cycle, so an off-by-one at the overlap or at expiry shows up as a mismatch in a single cycle.

// File: rtl/sndbus_pkg.sv
`timescale 1ns/1ps
package sndbus_pkg;

    localparam int NUNIT = 5;

    typedef enum logic [2:0] {
        UNIT_NONE = 3'd0,
        UNIT_TONE = 3'd1,
        UNIT_RHY  = 3'd2,
        UNIT_FMG  = 3'd3,
        UNIT_FMC  = 3'd4,
        UNIT_SMP  = 3'd5
    } unit_e;

    typedef struct packed {
        logic [7:0]       addr;
        logic             wr_prev;
        logic [NUNIT-1:0] we;
        logic [7:0]       wa;
        logic [7:0]       wd;
        logic             hi;
    } hif_st_t;

    // Register number plus bank to owning sub-unit
    function automatic unit_e map_unit(input logic bank, input logic [7:0] a);
        unit_e u;
        u = UNIT_NONE;
        if (!bank) begin
            if (a <= 8'h0F)                    u = UNIT_TONE;
            else if (a <= 8'h1F)               u = UNIT_RHY;
            else if (a <= 8'h2F)               u = UNIT_FMG;
            else if (a <= 8'hB6)               u = UNIT_FMC;
        end else begin
            if (a <= 8'h10)                    u = UNIT_SMP;
            else if (a >= 8'h30 && a <= 8'hB6) u = UNIT_FMC;
        end
        return u;
    endfunction

endpackage

// File: rtl/sndbus_wait_sel.sv
`timescale 1ns/1ps
module sndbus_wait_sel
    import sndbus_pkg::*;
#(
    parameter int CW        = 10,
    parameter int W_ADDR    = 17,
    parameter int W_FM_LO   = 83,
    parameter int W_FM_HI   = 47,
    parameter int W_RHY_KEY = 576,
    parameter int W_RHY     = 83
) (
    input  logic          bank,
    input  logic [7:0]    addr,
    input  logic          data_phase,
    output unit_e         unit,
    output logic [CW-1:0] wait_cyc
);

    always_comb begin
        unit     = map_unit(bank, addr);
        wait_cyc = '0;
        if (!data_phase) begin
            if (unit == UNIT_RHY || unit == UNIT_FMG || unit == UNIT_FMC)
                wait_cyc = CW'(W_ADDR);
        end else begin
            case (unit)
                UNIT_RHY: wait_cyc = (addr == 8'h10) ? CW'(W_RHY_KEY) : CW'(W_RHY);
                UNIT_FMG: wait_cyc = CW'(W_FM_LO);
                UNIT_FMC: wait_cyc = (addr >= 8'hA0) ? CW'(W_FM_HI) : CW'(W_FM_LO);
                default:  wait_cyc = '0;
            endcase
        end
    end

endmodule

// File: rtl/sndbus_busy_ctr.sv
`timescale 1ns/1ps
module sndbus_busy_ctr #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/sndbus_rd_mux.sv
`timescale 1ns/1ps
module sndbus_rd_mux #(
    parameter logic [7:0] ID_VAL = 8'h01
) (
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       a1,
    input  logic       a0,
    input  logic [7:0] reg_num,
    input  logic       busy,
    input  logic [6:0] stat0_flags,
    input  logic [6:0] stat1_flags,
    input  logic [7:0] tone_rdata,
    input  logic [7:0] adp_rdata,
    output logic [7:0] d_out,
    output logic       d_oe
);

    always_comb begin
        d_oe  = !cs_n && !rd_n && wr_n;
        d_out = 8'h00;
        if (d_oe) begin
            if (!a0) begin
                d_out = {busy, (a1 ? stat1_flags : stat0_flags)};
            end else if (!a1) begin
                if (reg_num <= 8'h0F)      d_out = tone_rdata;
                else if (reg_num == 8'hFF) d_out = ID_VAL;
            end else begin
                if (reg_num == 8'h08 || reg_num == 8'h0F) d_out = adp_rdata;
            end
        end
    end

endmodule

// File: rtl/sndbus_host_if.sv
`timescale 1ns/1ps
module sndbus_host_if
    import sndbus_pkg::*;
#(
    parameter logic [7:0] ID_VAL    = 8'h01,
    parameter int         W_ADDR    = 17,
    parameter int         W_FM_LO   = 83,
    parameter int         W_FM_HI   = 47,
    parameter int         W_RHY_KEY = 576,
    parameter int         W_RHY     = 83
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             a1,
    input  logic             a0,
    input  logic [7:0]       d_in,
    output logic [7:0]       d_out,
    output logic             d_oe,
    output logic [7:0]       reg_addr,
    output logic [NUNIT-1:0] unit_we,
    output logic [7:0]       wr_addr,
    output logic [7:0]       wr_data,
    output logic             wr_hi,
    input  logic [7:0]       tone_rdata,
    input  logic [7:0]       adp_rdata,
    input  logic [6:0]       stat0_flags,
    input  logic [6:0]       stat1_flags
);

    localparam int MAX_A = (W_ADDR > W_FM_LO) ? W_ADDR : W_FM_LO;
    localparam int MAX_B = (W_FM_HI > W_RHY) ? W_FM_HI : W_RHY;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_W = (MAX_C > W_RHY_KEY) ? MAX_C : W_RHY_KEY;
    localparam int CW    = $clog2(MAX_W + 1);

    hif_st_t st_d, st_q;

    logic             wr_act;
    logic             wr_evt;
    logic [7:0]       dec_addr;
    unit_e            dec_unit;
    logic [CW-1:0]    dec_wait;
    logic [NUNIT-1:0] dec_we;
    logic             busy;
    logic [7:0]       lat_addr;

    assign wr_act   = !cs_n && !wr_n && rd_n;
    assign wr_evt   = wr_act && !st_q.wr_prev;
    assign lat_addr = st_q.addr;
    assign dec_addr = a0 ? st_q.addr : d_in;

    sndbus_wait_sel #(
        .CW(CW), .W_ADDR(W_ADDR), .W_FM_LO(W_FM_LO), .W_FM_HI(W_FM_HI),
        .W_RHY_KEY(W_RHY_KEY), .W_RHY(W_RHY)
    ) u_sel (
        .bank       (a1),
        .addr       (dec_addr),
        .data_phase (a0),
        .unit       (dec_unit),
        .wait_cyc   (dec_wait)
    );

    for (genvar g = 0; g < NUNIT; g++) begin : g_we
        assign dec_we[g] = (dec_unit == unit_e'(3'(g + 1)));
    end

    sndbus_busy_ctr #(.CW(CW)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_evt),
        .load_val (dec_wait),
        .busy     (busy)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_act;
        st_d.we      = '0;
        if (wr_evt) begin
            if (!a0) begin
                st_d.addr = d_in;
            end else begin
                st_d.we = dec_we;
                st_d.wa = st_q.addr;
                st_d.wd = d_in;
                st_d.hi = a1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sndbus_rd_mux #(.ID_VAL(ID_VAL)) u_rd (
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .a1          (a1),
        .a0          (a0),
        .reg_num     (st_q.addr),
        .busy        (busy),
        .stat0_flags (stat0_flags),
        .stat1_flags (stat1_flags),
        .tone_rdata  (tone_rdata),
        .adp_rdata   (adp_rdata),
        .d_out       (d_out),
        .d_oe        (d_oe)
    );

    assign reg_addr = st_q.addr;
    assign unit_we  = st_q.we;
    assign wr_addr  = st_q.wa;
    assign wr_data  = st_q.wd;
    assign wr_hi    = st_q.hi;

endmodule

// File: rtl/sndbus_host_if_chk.sv
`timescale 1ns/1ps
module sndbus_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [4:0] unit_we,
    input logic [7:0] wr_addr,
    input logic [7:0] lat_addr,
    input logic       busy
);

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_we));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_we) |=> (unit_we == 5'b0));

    assert_write_uses_held_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_we) |-> (wr_addr == $past(lat_addr)));

    assert_slow_units_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we[1] || unit_we[2] || unit_we[3]) |-> busy);

    assert_fast_units_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we[0] || unit_we[4]) |-> !busy);

    assert_busy_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs_n && !wr_n && rd_n));

endmodule

bind sndbus_host_if sndbus_host_if_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .unit_we  (unit_we),
    .wr_addr  (wr_addr),
    .lat_addr (lat_addr),
    .busy     (busy)
);

// File: tb/sndbus_host_if_test.sv
`timescale 1ns/1ps
module sndbus_host_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a1 = 1'b0, a0 = 1'b0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out, reg_addr, wr_addr, wr_data, tone_rdata;
    logic       d_oe, wr_hi;
    logic [4:0] unit_we;
    logic [7:0] adp_rdata = 8'h3C;
    logic [6:0] stat0_flags = 7'h15, stat1_flags = 7'h2A;

    assign tone_rdata = {4'h5, reg_addr[3:0]};

    always #2 clk = ~clk;

    sndbus_host_if uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a1(a1), .a0(a0), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .reg_addr(reg_addr), .unit_we(unit_we), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_hi(wr_hi), .tone_rdata(tone_rdata),
        .adp_rdata(adp_rdata), .stat0_flags(stat0_flags), .stat1_flags(stat1_flags)
    );

    int  total = 0, bad = 0;
    bit  done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic int exp_unit(input bit bank, input int a);
        if (!bank) begin
            if (a < 16)   return 0;
            if (a < 32)   return 1;
            if (a < 48)   return 2;
            if (a <= 182) return 3;
            return -1;
        end
        if (a <= 16) return 4;
        if (a >= 48 && a <= 182) return 3;
        return -1;
    endfunction

    function automatic int exp_wait(input bit bank, input int a, input bit dph);
        int u;
        u = exp_unit(bank, a);
        if (!dph) return (u >= 1 && u <= 3) ? 17 : 0;
        if (u == 1) return (a == 16) ? 576 : 83;
        if (u == 2) return 83;
        if (u == 3) return (a >= 160) ? 47 : 83;
        return 0;
    endfunction

    int m_addr, m_cnt, m_we, m_wa, m_wd, m_hi;
    bit m_prev, m_act;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_we = -1; m_wa = 0; m_wd = 0; m_hi = 0; m_prev = 0;
        end else begin
            m_act = !cs_n && !wr_n && rd_n;
            m_we  = -1;
            if (m_act && !m_prev) begin
                if (!a0) begin
                    m_addr = int'(d_in);
                    m_cnt  = exp_wait(a1, m_addr, 0);
                end else begin
                    m_we  = exp_unit(a1, m_addr);
                    m_wa  = m_addr;
                    m_wd  = int'(d_in);
                    m_hi  = a1;
                    m_cnt = exp_wait(a1, m_addr, 1);
                end
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
            m_prev = m_act;
        end
    end

    int exp_we, exp_do;
    bit exp_oe;

    always @(negedge clk) begin
        if (rst_n) begin
            exp_we = (m_we >= 0) ? (1 << m_we) : 0;
            chk(int'(unit_we) == exp_we, "R4 strobe routing", unit_we, exp_we);
            if (m_we >= 0) begin
                chk(int'(wr_addr) == m_wa, "R2 write address", wr_addr, m_wa);
                chk(int'({wr_hi, wr_data}) == (m_hi * 256 + m_wd), "R3 write data/bank",
                    {wr_hi, wr_data}, m_hi * 256 + m_wd);
            end
            chk(int'(reg_addr) == m_addr, "R2 held address", reg_addr, m_addr);
            exp_oe = !cs_n && !rd_n && wr_n;
            chk(d_oe == exp_oe, "R11 bus enable", d_oe, exp_oe);
            exp_do = 0;
            if (exp_oe) begin
                if (!a0)
                    exp_do = ((m_cnt != 0) ? 128 : 0) + (a1 ? 'h2A : 'h15);
                else if (!a1)
                    exp_do = (m_addr < 16) ? ('h50 + m_addr) : ((m_addr == 255) ? 1 : 0);
                else
                    exp_do = (m_addr == 8 || m_addr == 15) ? 'h3C : 0;
            end
            chk(int'(d_out) == exp_do, a0 ? "R10 data read" : "R9/R7 status read", d_out, exp_do);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle_step();
        @(posedge clk); #1;
        cs_n = 1; rd_n = 1; wr_n = 1;
    endtask

    task automatic wr_step(input bit bank, input bit sel, input logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 0; rd_n = 1; wr_n = 0; a1 = bank; a0 = sel; d_in = d;
    endtask

    task automatic rd_step(input bit bank, input bit sel);
        @(posedge clk); #1;
        cs_n = 0; rd_n = 0; wr_n = 1; a1 = bank; a0 = sel;
    endtask

    task automatic addr_wr(input bit bank, input logic [7:0] a);
        wr_step(bank, 0, a);
        idle_step();
    endtask

    task automatic data_wr(input bit bank, input logic [7:0] d, input int exp_bits, input string tag);
        wr_step(bank, 1, d);
        idle_step();
        @(negedge clk);
        chk(int'(unit_we) == exp_bits, tag, unit_we, exp_bits);
    endtask

    // write, then poll status and count the busy periods
    task automatic wr_then_len(input bit bank, input bit sel, input logic [7:0] d, output int n);
        wr_step(bank, sel, d);
        rd_step(bank, 0);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (d_out[7]) n++;
            else break;
        end
        idle_step();
    endtask

    int n;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(unit_we == 5'b0 && d_oe == 1'b0 && reg_addr == 8'h00, "R1 reset state",
            {unit_we, d_oe, reg_addr}, 0);
        rd_step(0, 0);
        @(negedge clk);
        chk(d_out == 8'h15, "R1 busy clear after reset", d_out, 8'h15);
        idle_step();

        // R5 address-phase waits
        wr_then_len(0, 0, 8'h03, n); chk(n == 0,  "R5 tone address wait", n, 0);
        wr_then_len(0, 0, 8'h10, n); chk(n == 17, "R5 drum address wait", n, 17);
        wr_then_len(0, 0, 8'h25, n); chk(n == 17, "R5 FM global address wait", n, 17);
        wr_then_len(1, 0, 8'h10, n); chk(n == 0,  "R5 sample address wait", n, 0);
        wr_then_len(1, 0, 8'h50, n); chk(n == 17, "R5 FM channel bank1 address wait", n, 17);
        wr_then_len(1, 0, 8'h20, n); chk(n == 0,  "R5 unmapped address wait", n, 0);

        // R6 / R7 data-phase waits
        addr_wr(0, 8'h03); wr_then_len(0, 1, 8'hA5, n); chk(n == 0,   "R6 tone data wait", n, 0);
        addr_wr(0, 8'h10); wr_then_len(0, 1, 8'h01, n); chk(n == 576, "R6 drum key wait", n, 576);
        addr_wr(0, 8'h18); wr_then_len(0, 1, 8'h3F, n); chk(n == 83,  "R6 drum level wait", n, 83);
        addr_wr(0, 8'h28); wr_then_len(0, 1, 8'hF0, n); chk(n == 83,  "R6 FM global data wait", n, 83);
        addr_wr(1, 8'hA4); wr_then_len(1, 1, 8'h22, n); chk(n == 47,  "R6 FM freq data wait", n, 47);
        addr_wr(1, 8'h9E); wr_then_len(1, 1, 8'h11, n); chk(n == 83,  "R7 FM upper-edge data wait", n, 83);
        addr_wr(1, 8'h08); wr_then_len(1, 1, 8'h77, n); chk(n == 0,   "R6 sample data wait", n, 0);

        // R4 routing, R2 held address, R3 data/bank
        addr_wr(0, 8'h05);
        data_wr(0, 8'h11, 5'b00001, "R4 tone strobe");
        chk(wr_addr == 8'h05 && wr_data == 8'h11, "R3 first write fields", {wr_addr, wr_data}, 16'h0511);
        data_wr(0, 8'h22, 5'b00001, "R4 tone strobe again");
        chk(wr_addr == 8'h05, "R2 reused address", wr_addr, 8'h05);
        addr_wr(0, 8'h1A); data_wr(0, 8'h33, 5'b00010, "R4 drum strobe");
        addr_wr(0, 8'h2B); data_wr(0, 8'h44, 5'b00100, "R4 FM global strobe");
        addr_wr(1, 8'hB6); data_wr(1, 8'h55, 5'b01000, "R4 FM channel strobe");
        chk(wr_hi == 1'b1, "R3 bank carried", wr_hi, 1);
        addr_wr(1, 8'h10); data_wr(1, 8'h66, 5'b10000, "R4 sample strobe");
        addr_wr(0, 8'hC0); data_wr(0, 8'h99, 5'b00000, "R4 unmapped bank0 no strobe");
        addr_wr(1, 8'h20); data_wr(1, 8'h99, 5'b00000, "R4 unmapped bank1 no strobe");

        // R3 held strobe gives a single write
        addr_wr(0, 8'h02);
        wr_step(0, 1, 8'h77);
        n = 0;
        repeat (4) begin @(negedge clk); n += int'(|unit_we); end
        idle_step();
        chk(n == 1, "R3 single write for held strobe", n, 1);

        // R8 write while busy restarts the wait
        addr_wr(0, 8'h40);
        wr_step(0, 1, 8'h12);
        rd_step(0, 0);
        repeat (20) @(negedge clk);
        chk(d_out[7] == 1'b1, "R8 busy mid-wait", d_out[7], 1);
        wr_then_len(0, 1, 8'h34, n);
        chk(n == 83, "R8 restarted wait length", n, 83);
        addr_wr(0, 8'hA0);
        wr_step(0, 1, 8'h01);
        rd_step(0, 0);
        repeat (10) @(negedge clk);
        wr_then_len(0, 1, 8'h02, n);
        chk(n == 47, "R8 restart with short wait", n, 47);

        // R9 status bytes, R10 data reads
        repeat (100) idle_step();
        rd_step(0, 0); @(negedge clk); chk(d_out == 8'h15, "R9 status 0", d_out, 8'h15);
        rd_step(1, 0); @(negedge clk); chk(d_out == 8'h2A, "R9 status 1", d_out, 8'h2A);
        addr_wr(0, 8'h07);
        rd_step(0, 1); @(negedge clk); chk(d_out == 8'h57, "R10 tone readback", d_out, 8'h57);
        addr_wr(0, 8'hFF);
        rd_step(0, 1); @(negedge clk); chk(d_out == 8'h01, "R10 ID byte", d_out, 8'h01);
        addr_wr(0, 8'h20);
        rd_step(0, 1); @(negedge clk); chk(d_out == 8'h00, "R10 non-readable", d_out, 0);
        addr_wr(1, 8'h08);
        rd_step(1, 1); @(negedge clk); chk(d_out == 8'h3C, "R10 sample data 08", d_out, 8'h3C);
        addr_wr(1, 8'h0F);
        rd_step(1, 1); @(negedge clk); chk(d_out == 8'h3C, "R10 sample data 0F", d_out, 8'h3C);
        addr_wr(1, 8'h09);
        rd_step(1, 1); @(negedge clk); chk(d_out == 8'h00, "R10 sample other", d_out, 0);

        // R11 chip select high releases the bus
        @(posedge clk); #1; cs_n = 1; rd_n = 0; wr_n = 1; a0 = 0;
        @(negedge clk);
        chk(d_oe == 1'b0 && d_out == 8'h00, "R11 released when deselected", {d_oe, d_out}, 0);
        idle_step();
        repeat (4) @(posedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule